// File: doc/BRIEF.md
# Torus Dimension-Order Next-Hop Selector

This block sits at the head of each input of a torus router. It takes the mixed-radix address of the local node and the destination address carried by a message header. From these it decides which output the header leaves through, or whether it leaves toward the local processing element. It also decides which virtual channels on that output the header may claim, given the current busy state of every channel. Dimensions are resolved in a fixed ascending order, so a dimension is routed only after every lower dimension already agrees with the destination.

Each dimension has its own radix. A parameter selects one of two link options: a single positive output per dimension, or a positive and a negative output per dimension. A second parameter selects how channels are assigned. The first scheme is a class split: headers whose local digit is below the destination digit use the upper channels, and all others use the lower channels. The second scheme is a shared pool backed by two escape channels whose use depends on the same comparison. Either way, a deadlock-free channel is chosen across the wrap-around link. The result is registered once per header, and the request is one-hot, or empty when the header must stay where it is.

Top module: `torus_route`

## Requirements
- R1: After reset, out_valid, out_eject, out_blocked and out_vc_req are all 0.
- R2: out_valid is high in exactly the cycle after each cycle in which hdr_valid is high, and the outputs in that cycle describe that header.
- R3: The routed dimension is the lowest-indexed dimension whose current digit differs from the destination digit.
- R4: When every digit matches, out_eject is 1, out_port equals the number of network outputs (N_DIM when unidirectional, 2*N_DIM when bidirectional), out_vc_req is 0 and out_blocked is 0.
- R5: With unidirectional links, a header routed in dimension d leaves on port d.
- R6: With bidirectional links, a header routed in dimension d leaves on port 2d (positive) when the forward distance (dst - cur) mod k_d is at most floor(k_d/2), and on port 2d+1 (negative) otherwise; a tie at exactly k_d/2 goes positive.
- R7: Class-split scheme: if cur digit < dst digit, the permitted channels are indices NUM_LOW..NUM_VC-1, otherwise 0..NUM_LOW-1; the lowest-indexed free permitted channel is requested.
- R8: Pool scheme: the lowest-indexed free channel among indices 2..NUM_VC-1 is requested whenever one is free.
- R9: Pool scheme: when the whole pool is busy, escape channel 0 is requested if cur digit < dst digit, otherwise escape channel 1, provided that channel is free.
- R10: When no permitted channel is free, out_blocked is 1 and out_vc_req is 0; a requested channel is never one marked busy.
- R11: out_vc_req has at most one bit set. Channel index j of port p is bit p*NUM_VC+j of vc_busy, and busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | A header is presented this cycle |
| cur_addr | input | N_DIM*DW | Local node digits, dimension 0 in the low bits |
| dst_addr | input | N_DIM*DW | Destination digits, same layout |
| vc_busy | input | NPORT*NUM_VC | Busy flag per channel per network output |
| out_valid | output | 1 | Result for the header of the previous cycle |
| out_port | output | PW | Chosen output; NPORT denotes ejection |
| out_eject | output | 1 | Header has arrived |
| out_vc_req | output | NUM_VC | One-hot channel request, or 0 |
| out_blocked | output | 1 | No permitted channel is free |

## Verification
Two copies run side by side on the same stimulus: one with bidirectional links and the pool scheme, and one with unidirectional links and the class split. A shared header therefore shows apart the link options and the channel schemes. Address pairs are picked so that the first mismatch falls in different dimensions while higher dimensions also differ. They also produce forward distances below, at and above half the radix, with the local digit both below and above the destination. A sweep over one dimension's digit pairs covers every direction decision. Busy masks are then chosen to empty the pool, one escape or one class in turn, which separates ordinary grants from escape grants and from blocking.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;
   // Lowest set bit of a channel vector, kept one-hot.
   function automatic logic [63:0] lowest_bit(input logic [63:0] v);
      return v & (~v + 64'd1);
   endfunction
endpackage

// File: rtl/tr_dim_select.sv
module tr_dim_select #(
   parameter int unsigned N_DIM     = 3,
   parameter int unsigned DW        = 3,
   parameter int unsigned RW        = 8,
   parameter logic [N_DIM*RW-1:0] RADIX_VEC = {8'd5, 8'd4, 8'd3},
   parameter bit          BIDIR     = 1'b1,
   localparam int unsigned IW       = (N_DIM > 1) ? $clog2(N_DIM) : 1
) (
   input  logic [N_DIM*DW-1:0] cur,
   input  logic [N_DIM*DW-1:0] dst,
   output logic                found,
   output logic [IW-1:0]       dim,
   output logic                neg,
   output logic                hi
);
   logic [N_DIM-1:0] mis_v, neg_v, hi_v;

   for (genvar d = 0; d < N_DIM; d++) begin : g_dim
      localparam logic [31:0] KV = 32'(RADIX_VEC[d*RW +: RW]);
      if (KV < 2 || KV > (32'd1 << DW)) begin : g_bad_radix
         $error("radix of a dimension out of range");
      end
      logic [DW-1:0] c, t;
      logic [31:0]   fwd;
      assign c = cur[d*DW +: DW];
      assign t = dst[d*DW +: DW];
      assign fwd = (t >= c) ? (32'(t) - 32'(c)) : (32'(t) + KV - 32'(c));
      assign mis_v[d] = (c != t);
      assign hi_v[d]  = (c < t);
      if (BIDIR) begin : g_bi
         assign neg_v[d] = (fwd > (KV >> 1));
      end else begin : g_uni
         assign neg_v[d] = 1'b0;
      end
   end

   always_comb begin
      found = 1'b0;
      dim   = '0;
      neg   = 1'b0;
      hi    = 1'b0;
      for (int d = N_DIM - 1; d >= 0; d--) begin
         if (mis_v[d]) begin
            found = 1'b1;
            dim   = IW'(d);
            neg   = neg_v[d];
            hi    = hi_v[d];
         end
      end
   end
endmodule

// File: rtl/tr_vc_select.sv
module tr_vc_select
   import torus_route_pkg::*;
#(
   parameter int unsigned NUM_VC  = 4,
   parameter int unsigned NUM_LOW = 2,
   parameter int unsigned VC_ORG  = 2
) (
   input  logic [NUM_VC-1:0] busy,
   input  logic              hi,
   output logic [NUM_VC-1:0] grant,
   output logic              blocked
);
   if (NUM_VC < 2 || NUM_VC > 64) begin : g_bad_vc
      $error("channel count must be 2..64");
   end

   if (VC_ORG == 1) begin : g_split
      if (NUM_LOW < 1 || NUM_LOW > NUM_VC - 1) begin : g_bad_low
         $error("low class size out of range");
      end
      localparam logic [NUM_VC-1:0] LOWM = {NUM_VC{1'b1}} >> (NUM_VC - NUM_LOW);
      logic [NUM_VC-1:0] allowed, free;
      logic [63:0]       pick;
      assign allowed = hi ? ~LOWM : LOWM;
      assign free    = allowed & ~busy;
      assign pick    = lowest_bit(64'(free));
      assign grant   = pick[NUM_VC-1:0];
      assign blocked = (free == '0);
   end else if (VC_ORG == 2) begin : g_pool
      localparam logic [NUM_VC-1:0] POOL = {NUM_VC{1'b1}} << 2;
      logic [NUM_VC-1:0] pool_free, esc, esc_free;
      logic [63:0]       pick;
      assign pool_free = POOL & ~busy;
      assign esc       = hi ? NUM_VC'(1) : NUM_VC'(2);
      assign esc_free  = esc & ~busy;
      assign pick      = lowest_bit(64'(pool_free));
      assign grant     = (pool_free != '0) ? pick[NUM_VC-1:0] : esc_free;
      assign blocked   = (pool_free == '0) && (esc_free == '0);
   end else begin : g_bad_org
      $error("channel scheme must be 1 or 2");
      assign grant   = '0;
      assign blocked = 1'b1;
   end
endmodule

// File: rtl/torus_route.sv
module torus_route #(
   parameter int unsigned N_DIM     = 3,
   parameter int unsigned DW        = 3,
   parameter int unsigned RW        = 8,
   parameter logic [N_DIM*RW-1:0] RADIX_VEC = {8'd5, 8'd4, 8'd3},
   parameter bit          BIDIR     = 1'b1,
   parameter int unsigned VC_ORG    = 2,
   parameter int unsigned NUM_VC    = 4,
   parameter int unsigned NUM_LOW   = 2,
   localparam int unsigned NPORT    = BIDIR ? 2 * N_DIM : N_DIM,
   localparam int unsigned PW       = $clog2(NPORT + 1),
   localparam int unsigned IW       = (N_DIM > 1) ? $clog2(N_DIM) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hdr_valid,
   input  logic [N_DIM*DW-1:0]     cur_addr,
   input  logic [N_DIM*DW-1:0]     dst_addr,
   input  logic [NPORT*NUM_VC-1:0] vc_busy,
   output logic                    out_valid,
   output logic [PW-1:0]           out_port,
   output logic                    out_eject,
   output logic [NUM_VC-1:0]       out_vc_req,
   output logic                    out_blocked
);
   if (N_DIM < 1) begin : g_bad_dim
      $error("at least one dimension is needed");
   end

   logic              found, neg, hi, blocked;
   logic [IW-1:0]     dim;
   logic [PW-1:0]     port_nxt, sel_idx;
   logic [NUM_VC-1:0] busy_sel, grant;
   logic [NUM_VC-1:0] busy_arr [NPORT];

   tr_dim_select #(
      .N_DIM(N_DIM), .DW(DW), .RW(RW), .RADIX_VEC(RADIX_VEC), .BIDIR(BIDIR)
   ) u_dim (
      .cur(cur_addr), .dst(dst_addr), .found(found), .dim(dim), .neg(neg), .hi(hi)
   );

   if (BIDIR) begin : g_port_bi
      assign port_nxt = found ? ((PW'(dim) << 1) | PW'(neg)) : PW'(NPORT);
   end else begin : g_port_uni
      assign port_nxt = found ? PW'(dim) : PW'(NPORT);
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_busy
      assign busy_arr[p] = vc_busy[p*NUM_VC +: NUM_VC];
   end
   assign sel_idx  = found ? port_nxt : '0;
   assign busy_sel = busy_arr[sel_idx];

   tr_vc_select #(
      .NUM_VC(NUM_VC), .NUM_LOW(NUM_LOW), .VC_ORG(VC_ORG)
   ) u_vc (
      .busy(busy_sel), .hi(hi), .grant(grant), .blocked(blocked)
   );

   logic [NUM_VC-1:0] busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_port    <= '0;
         out_eject   <= 1'b0;
         out_vc_req  <= '0;
         out_blocked <= 1'b0;
         busy_q      <= '0;
      end else begin
         out_valid <= hdr_valid;
         if (hdr_valid) begin
            out_port    <= port_nxt;
            out_eject   <= !found;
            out_vc_req  <= found ? grant : '0;
            out_blocked <= found && blocked;
            busy_q      <= found ? busy_sel : '0;
         end
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> out_valid);
   // R11
   req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_vc_req));
   // R10
   blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_blocked |-> (out_vc_req == '0));
   // R10
   no_busy_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_vc_req & busy_q) == '0));
   // R4
   eject_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_eject) |-> (!out_blocked && out_vc_req == '0 && out_port == PW'(NPORT)));
endmodule

// File: tb/torus_route_bench.sv
`timescale 1ns/1ps
module torus_route_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid = 1'b0;
   logic [8:0]  cur_addr = '0, dst_addr = '0;
   logic [23:0] vc_busy = '0;

   logic       va, ea, ba, vb, eb, bb;
   logic [2:0] pa;
   logic [1:0] pb;
   logic [3:0] ra, rb;

   always #2 clk = ~clk;

   torus_route u_torus_route (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .cur_addr(cur_addr),
      .dst_addr(dst_addr), .vc_busy(vc_busy), .out_valid(va), .out_port(pa),
      .out_eject(ea), .out_vc_req(ra), .out_blocked(ba));

   torus_route #(.BIDIR(1'b0), .VC_ORG(1)) u_torus_route_uni (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .cur_addr(cur_addr),
      .dst_addr(dst_addr), .vc_busy(vc_busy[11:0]), .out_valid(vb), .out_port(pb),
      .out_eject(eb), .out_vc_req(rb), .out_blocked(bb));

   typedef struct {
      int       port;
      bit       eject;
      bit [3:0] req;
      bit       blocked;
      string    tag;
   } exp_t;

   exp_t qa[$], qb[$];
   int checks = 0, errors = 0;
   bit done = 1'b0;
   localparam int K [3] = '{3, 4, 5};

   function automatic logic [8:0] addr(int a2, int a1, int a0);
      return {3'(a2), 3'(a1), 3'(a0)};
   endfunction

   function automatic exp_t model(bit bidir, int org, logic [8:0] c, logic [8:0] t,
                                  logic [23:0] busy, string tag);
      exp_t e;
      int   d = -1;
      e.tag = tag; e.req = 0; e.blocked = 0; e.eject = 0;
      for (int i = 2; i >= 0; i--) if (c[i*3 +: 3] != t[i*3 +: 3]) d = i;
      if (d < 0) begin
         e.eject = 1; e.port = bidir ? 6 : 3;
      end else begin
         int cd = int'(c[d*3 +: 3]);
         int td = int'(dst_digit(t, d));
         int fwd = (td - cd + K[d]) % K[d];
         bit hi = cd < td;
         bit [3:0] b, free;
         e.port = bidir ? (2 * d + ((fwd > K[d] / 2) ? 1 : 0)) : d;
         b = busy[e.port*4 +: 4];
         if (org == 1) begin
            free = (hi ? 4'b1100 : 4'b0011) & ~b;
         end else begin
            free = 4'b1100 & ~b;
            if (free == 0) free = (hi ? 4'b0001 : 4'b0010) & ~b;
         end
         if (free == 0) e.blocked = 1;
         else e.req = free & (~free + 4'd1);
      end
      return e;
   endfunction

   function automatic logic [2:0] dst_digit(logic [8:0] t, int d);
      return t[d*3 +: 3];
   endfunction

   task automatic send(logic [8:0] c, logic [8:0] t, logic [23:0] busy,
                       string tag_a, string tag_b);
      @(negedge clk);
      cur_addr = c; dst_addr = t; vc_busy = busy; hdr_valid = 1'b1;
      qa.push_back(model(1'b1, 2, c, t, busy, tag_a));
      qb.push_back(model(1'b0, 1, c, t, busy, tag_b));
   endtask

   task automatic compare(string who, exp_t e, int port, bit ej, bit [3:0] req, bit blk);
      checks++;
      if (port != e.port || ej != e.eject || req != e.req || blk != e.blocked) begin
         errors++;
         $display("FAIL %s %s: port=%0d eject=%0b req=%b blocked=%0b expected port=%0d eject=%0b req=%b blocked=%0b",
                  e.tag, who, port, ej, req, blk, e.port, e.eject, e.req, e.blocked);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && va) begin
         if (qa.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 bidir: out_valid=1 expected 0");
         end else compare("bidir", qa.pop_front(), int'(pa), ea, ra, ba);
      end
      if (rst_n && vb) begin
         if (qb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 uni: out_valid=1 expected 0");
         end else compare("uni", qb.pop_front(), int'(pb), eb, rb, bb);
      end
   end

   task automatic expect_bit(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      expect_bit("R1 valid", va | vb, 1'b0);
      expect_bit("R1 flags", ea | eb | ba | bb, 1'b0);
      expect_bit("R1 req", |{ra, rb}, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_bit("R1 valid after release", va | vb, 1'b0);

      send(addr(2,1,0), addr(2,1,0), 24'h0, "R4", "R4");
      send(addr(0,0,0), addr(0,0,1), 24'h0, "R6", "R5");
      send(addr(0,0,0), addr(0,0,2), 24'h0, "R6", "R7");
      send(addr(0,0,0), addr(0,2,0), 24'h0, "R6", "R5");
      send(addr(3,1,1), addr(1,3,1), 24'h0, "R3", "R3");
      send(addr(3,0,0), addr(1,0,0), 24'h0, "R6", "R7");
      send(addr(0,0,0), addr(0,0,1), 24'h00C, "R9", "R10");
      send(addr(0,0,2), addr(0,0,0), 24'h00C, "R9", "R7");
      send(addr(0,0,2), addr(0,0,0), 24'h00E, "R10", "R7");
      send(addr(0,0,0), addr(0,0,1), 24'h004, "R8", "R7");
      send(addr(0,0,1), addr(0,0,0), 24'h001, "R6", "R7");
      send(addr(4,3,2), addr(4,3,2), 24'hFFFFFF, "R4", "R4");
      @(negedge clk); hdr_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R2 no result without a header
      expect_bit("R2 idle", va | vb, 1'b0);

      for (int c = 0; c < 4; c++) begin
         for (int t = 0; t < 4; t++) begin
            send(addr(1,c,2), addr(1,t,2), 24'h0, "R6", "R5");
         end
      end
      @(negedge clk); hdr_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R2 every header produced exactly one result
      expect_bit("R2 drained", (qa.size() != 0) || (qb.size() != 0), 1'b0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule